// File: doc/BRIEF.md
# Port Interrupt Status and Enable Unit

This block holds the interrupt state for a group of storage-controller ports and the host-level word that gathers them. Each port captures single-cycle event pulses into sticky raw status bits. A per-port enable mask selects which of these bits raise the port's interrupt line. Software changes the mask only through separate set and clear registers, so it never needs a read-modify-write. One control bit selects how status is cleared. In one mode software writes ones to clear bits. In the other mode a read of the status word clears the bits that the read returned.

A host register shows one pending bit per port, gated by a host control mask. The OR of those bits drives the host interrupt line. All registers sit on a simple single-cycle read/write bus. Address bit 5 selects the host registers. Otherwise bits 4:3 pick the port and bits 2:0 pick the register inside that port.

Top module: `irq_hub`

## Requirements
- R1: Reading port register 0 returns the masked status (raw AND enable) in bits 11:0 and the raw status in bits 27:16. Events sit at bit 0 (complete), 1 (error), 2 (port-ready change), 3 (power change), 4 (PHY-ready change), 5 (wake received), 6 (unknown frame) and 11 (set-device-bits frame). Pulses on bits 10:7 are ignored and read as 0.
- R2: Writing port register 1 sets each enable bit whose data bit 11:0 is one. Zero bits leave enables unchanged. A read of register 1 returns the enables in bits 11:0.
- R3: Writing port register 2 clears each enable bit whose data bit is one. Zero bits leave enables unchanged.
- R4: Any write to register 1 or register 2 loads data bits 31:30 into a 2-bit steering field. A read of register 1 returns this field in bits 31:30.
- R5: The clear-mode bit sits at bit 3 of port register 3. Writing a one there through register 3 sets it, and writing a one there through register 4 clears it. A read of register 3 returns it at bit 3.
- R6: With clear-mode set, a write to register 0 clears each raw bit i for which data bit i or bit i+16 is one, so 0x0fff0fff clears all of them. Reads of register 0 do not clear anything in this mode.
- R7: With clear-mode off, writes to register 0 have no effect. A read of register 0 clears the raw bits that the read returned, at the clock edge that ends the read.
- R8: An event pulse that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: Each port's irq output is the registered OR of its masked status, so it rises one cycle after the raw bit appears.
- R10: Host register 0 (address 0x20) reads port_irq AND host control in bits NPORTS-1:0. host_irq is the OR of those bits.
- R11: Host register 1 (address 0x21) is the read/write host control mask. Writing 0 masks every port and writing 0xF enables all four.
- R12: After reset all enables, raw bits, steering fields, clear-mode bits, host control bits and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read-clear) |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_in | input | NPORTS*12 | Event pulses, 12 bits per port, port 0 lowest |
| port_irq | output | NPORTS | Registered per-port interrupt |
| host_irq | output | 1 | Host interrupt |

## Verification
The bench targets a new event that lands in the same cycle as a write-one clear or a read-clear. A design that gives the clear priority would lose that event, so the bit would read back as zero. It writes enable-set and enable-clear values that are mostly zero bits. A design that copied the data instead of setting or clearing would wipe enables that were already on. It switches clear-mode while status is pending. A design that mixed up the two modes would either clear on reads in write-one mode or let writes through in read-clear mode. It also checks irq one cycle after an event and the host word under the all-off and all-on masks, which catches a missing register stage or a gate on the wrong side.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int EVW = 12;
   localparam logic [EVW-1:0] EVT_VALID = 12'h87F;
   localparam int RAW_SHIFT = 16;
   localparam int MODE_BIT = 3;
   typedef enum logic [2:0] {
      RG_STAT  = 3'd0,
      RG_ENSET = 3'd1,
      RG_ENCLR = 3'd2,
      RG_CSET  = 3'd3,
      RG_CCLR  = 3'd4
   } port_reg_e;
endpackage

// File: rtl/irq_port_regs.sv
module irq_port_regs
   import irq_hub_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic            rd,
   input  logic [2:0]      reg_idx,
   input  logic [31:0]     wdata,
   input  logic [EVW-1:0]  evt,
   output logic [31:0]     rdata,
   output logic            irq
);
   logic [EVW-1:0] raw, en, clr_mask, evt_v, masked;
   logic [1:0]     steer;
   logic           woc;
   logic           unused_bits;

   assign unused_bits = ^{wdata[29:28], wdata[15:12]};
   assign evt_v  = evt & EVT_VALID;
   assign masked = raw & en;

   always_comb begin
      clr_mask = '0;
      if (woc && wr && reg_idx == RG_STAT)
         clr_mask = wdata[EVW-1:0] | wdata[RAW_SHIFT+EVW-1:RAW_SHIFT];
      else if (!woc && rd && reg_idx == RG_STAT)
         clr_mask = raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw   <= '0;
         en    <= '0;
         steer <= '0;
         woc   <= 1'b0;
         irq   <= 1'b0;
      end else begin
         raw <= (raw & ~clr_mask) | evt_v;
         irq <= |masked;
         if (wr && reg_idx == RG_ENSET) begin
            en    <= en | (wdata[EVW-1:0] & EVT_VALID);
            steer <= wdata[31:30];
         end
         if (wr && reg_idx == RG_ENCLR) begin
            en    <= en & ~wdata[EVW-1:0];
            steer <= wdata[31:30];
         end
         if (wr && reg_idx == RG_CSET && wdata[MODE_BIT]) woc <= 1'b1;
         if (wr && reg_idx == RG_CCLR && wdata[MODE_BIT]) woc <= 1'b0;
      end
   end

   always_comb begin
      case (reg_idx)
         RG_STAT:  rdata = {4'b0, raw, 4'b0, masked};
         RG_ENSET: rdata = {steer, 18'b0, en};
         RG_CSET:  rdata = {28'b0, woc, 3'b0};
         default:  rdata = '0;
      endcase
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_v) |=> ((raw & $past(evt_v)) == $past(evt_v))); // R8
   AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|masked)); // R9
   AST_W1C_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (woc && rd && !wr && reg_idx == RG_STAT && evt_v == '0) |=> raw == $past(raw)); // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!woc && rd && reg_idx == RG_STAT && evt_v == '0) |=> raw == '0); // R7
   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_idx == RG_ENSET) |=>
      ((en & $past(wdata[EVW-1:0] & EVT_VALID)) == $past(wdata[EVW-1:0] & EVT_VALID))); // R2
endmodule

// File: rtl/irq_host_agg.sv
module irq_host_agg #(
   parameter int NPORTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        reg_idx,
   input  logic [31:0]       wdata,
   input  logic [NPORTS-1:0] port_irq,
   output logic [31:0]       rdata,
   output logic              host_irq
);
   logic [NPORTS-1:0] ctrl, pend;
   logic              unused_bits;

   assign unused_bits = ^{wdata[31:NPORTS], reg_idx[2:1]};
   assign pend = port_irq & ctrl;
   assign host_irq = |pend;

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl <= '0;
      else if (wr && reg_idx[0]) ctrl <= wdata[NPORTS-1:0];
   end

   assign rdata = reg_idx[0] ? 32'(ctrl) : 32'(pend);

   AST_HOST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == '0) |-> !host_irq); // R11
   AST_HOST_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (|port_irq)); // R10
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int NPORTS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [5:0]            bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NPORTS*EVW-1:0] evt_in,
   output logic [NPORTS-1:0]     port_irq,
   output logic                  host_irq
);
   localparam logic HOST_SEL = 1'b1;

   generate
      if (NPORTS < 1 || NPORTS > 4) begin : g_bad
         $error("irq_hub: NPORTS must be 1..4");
      end
   endgenerate

   logic [31:0] port_rdata [NPORTS];
   logic [31:0] host_rdata;
   logic        is_host;

   assign is_host = (bus_addr[5] == HOST_SEL);

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      assign hit = !is_host && (bus_addr[4:3] == 2'(p));
      irq_port_regs u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (bus_wr && hit),
         .rd      (bus_rd && hit),
         .reg_idx (bus_addr[2:0]),
         .wdata   (bus_wdata),
         .evt     (evt_in[p*EVW +: EVW]),
         .rdata   (port_rdata[p]),
         .irq     (port_irq[p])
      );
   end

   irq_host_agg #(.NPORTS(NPORTS)) u_host (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr && is_host),
      .reg_idx  (bus_addr[2:0]),
      .wdata    (bus_wdata),
      .port_irq (port_irq),
      .rdata    (host_rdata),
      .host_irq (host_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (is_host) bus_rdata = host_rdata;
      else
         for (int i = 0; i < NPORTS; i++)
            if (bus_addr[4:3] == 2'(i)) bus_rdata = port_rdata[i];
   end
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
   localparam int NP = 4;
   localparam logic [11:0] VM = 12'h87F;
   logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
   logic [5:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [NP*12-1:0] evt_in = '0;
   logic [NP-1:0] port_irq;
   logic host_irq;
   int checks = 0, fails = 0;
   logic [11:0] m_raw [NP], m_en [NP];
   logic [1:0] m_st [NP];
   logic m_woc [NP];
   logic [NP-1:0] m_hc;

   always #10 clk = ~clk;

   irq_hub #(.NPORTS(NP)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   function automatic logic [5:0] pa(input int p, input int r);
      return {1'b0, 2'(p), 3'(r)};
   endfunction

   function automatic logic [31:0] exp_stat(input int p);
      return {4'b0, m_raw[p], 4'b0, m_raw[p] & m_en[p]};
   endfunction

   function automatic logic [NP-1:0] exp_pirq();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = |(m_raw[p] & m_en[p]);
      return v;
   endfunction

   task automatic pulse(input int p, input logic [11:0] b);
      @(negedge clk); evt_in[p*12 +: 12] = b;
      @(negedge clk); evt_in = '0;
      m_raw[p] |= b & VM;
   endtask

   task automatic settle_check(input string tag);
      @(negedge clk);
      chk({tag, " R9 port_irq"}, 32'(port_irq), 32'(exp_pirq()));
      chk({tag, " R10 host_irq"}, 32'(host_irq), 32'(|(exp_pirq() & m_hc)));
   endtask

   task automatic read_stat(input int p, input string tag);
      logic [31:0] d;
      rd(pa(p, 0), d);
      chk({tag, " R1 status"}, d, exp_stat(p));
      if (!m_woc[p]) m_raw[p] = '0;
   endtask

   task automatic do_op(input int op, input int p, input logic [31:0] d);
      logic [31:0] r;
      case (op)
         0: pulse(p, d[11:0]);
         1: begin wr(pa(p,1), d); m_en[p] |= d[11:0] & VM; m_st[p] = d[31:30]; end
         2: begin wr(pa(p,2), d); m_en[p] &= ~d[11:0]; m_st[p] = d[31:30]; end
         3: begin wr(pa(p,3), d); if (d[3]) m_woc[p] = 1; end
         4: begin wr(pa(p,4), d); if (d[3]) m_woc[p] = 0; end
         5: begin wr(pa(p,0), d); if (m_woc[p]) m_raw[p] &= ~(d[11:0] | d[27:16]); end
         6: read_stat(p, "rand");
         7: begin wr(6'h21, d); m_hc = d[NP-1:0]; end
         8: begin rd(pa(p,1), r); chk("R2 R4 enable/steer read", r, {m_st[p], 18'b0, m_en[p]}); end
         9: begin rd(pa(p,3), r); chk("R5 mode read", r, {28'b0, m_woc[p], 3'b0}); end
         default: begin rd(6'h20, r); chk("R10 host status", r, 32'(exp_pirq() & m_hc)); end
      endcase
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd2024));
      for (int p = 0; p < NP; p++) begin m_raw[p] = 0; m_en[p] = 0; m_st[p] = 0; m_woc[p] = 0; end
      m_hc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      for (int p = 0; p < NP; p++) begin
         rd(pa(p,0), r); chk("R12 reset status", r, 0);
         rd(pa(p,1), r); chk("R12 reset enable/steer", r, 0);
         rd(pa(p,3), r); chk("R12 reset mode", r, 0);
      end
      rd(6'h21, r); chk("R12 reset host ctrl", r, 0);
      chk("R12 reset irq", {31'b0, host_irq} | 32'(port_irq), 0);

      // R1 invalid event positions ignored
      pulse(0, 12'h780); read_stat(0, "R1 invalid bits");
      // R2/R9: enable then event, irq one cycle later
      do_op(1, 0, 32'h0000_0001);
      @(negedge clk); evt_in[0] = 1;
      @(negedge clk); evt_in = '0; m_raw[0] |= 1;
      chk("R9 irq not yet", 32'(port_irq[0]), 0);
      @(negedge clk); chk("R9 irq after one cycle", 32'(port_irq[0]), 1);
      // R11 host mask off, then all on
      do_op(7, 0, 0); settle_check("R11 mask all");
      do_op(7, 0, 32'hF); settle_check("R11 enable all");
      do_op(10, 0, 0);
      // R2/R3 zero bits leave enables unchanged
      do_op(1, 0, 32'h0000_0800); do_op(2, 0, 32'h4000_0000);
      do_op(8, 0, 0);
      do_op(2, 0, 32'h8000_0001); do_op(8, 0, 0);
      // R7 read-clear mode: writes ignored
      pulse(1, 12'h87F); do_op(5, 1, 32'h0fff0fff); read_stat(1, "R7 write ignored");
      read_stat(1, "R7 cleared by read");
      // R6 write-one mode
      do_op(3, 1, 32'h8); do_op(9, 1, 0);
      pulse(1, 12'h87F); read_stat(1, "R6 pre"); read_stat(1, "R6 read keeps");
      do_op(5, 1, 32'h0001_0002); read_stat(1, "R6 partial clear");
      do_op(5, 1, 32'h0fff0fff); read_stat(1, "R6 clear all");
      // R8 collision with write-one clear
      @(negedge clk); evt_in[12 +: 12] = 12'h001; bus_wr = 1; bus_addr = pa(1,0); bus_wdata = 32'h0fff0fff;
      @(negedge clk); evt_in = '0; bus_wr = 0; m_raw[1] = 12'h001;
      read_stat(1, "R8 set wins over write clear");
      // R8 collision with read-clear
      do_op(4, 1, 32'h8); do_op(9, 1, 0);
      pulse(1, 12'h802);
      @(negedge clk); evt_in[12 +: 12] = 12'h010; bus_rd = 1; bus_addr = pa(1,0);
      #1 chk("R8 read value", bus_rdata, exp_stat(1));
      @(negedge clk); evt_in = '0; bus_rd = 0; m_raw[1] = 12'h010;
      read_stat(1, "R8 set wins over read clear");

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int op, p;
         logic [31:0] d;
         op = $urandom_range(0, 10);
         p  = $urandom_range(0, NP-1);
         d  = $urandom;
         if (op == 0) d = d & 32'h0000_0FFF & ((($urandom % 4) == 0) ? 32'hFFF : 32'h841);
         do_op(op, p, d);
         if (i % 8 == 0) settle_check("rand");
      end
      for (int p = 0; p < NP; p++) read_stat(p, "final");
      settle_check("final");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule